// File: doc/BRIEF.md
# Frame-Synchronised Serial Word Receiver

This block takes one sample word per frame from a three-wire serial link made of a bit clock, a frame sync and a data line. It presents that word on a parallel bus in a fast system clock domain. The bit clock is not related to the system clock. All three link wires pass through synchronisers and are edge-detected with the system clock. A frame opens on the rising edge of the sync line. From then on, every rising edge of the bit clock shifts in one data bit, most significant bit first, until the word is complete.

The word length is decided once per frame by two mode inputs. In sample mode the word is 8 bits wide. In code mode it is 4 bits wide, right-aligned on the output, and an optional three-bit setting forces the final code bit to zero. Bit clock edges after the word is complete are ignored. A fresh sync in the middle of a word throws away the partial word and starts over. Each completed word produces a single-cycle valid strobe, and the output word holds its value until the next strobe.

Top module: `frame_serial_rx`

## Requirements
- R1: While `rst` is high, `word_o` reads 0 and `word_valid_o` stays low. A reset in the middle of a frame discards the partial word, and no strobe follows until a new frame has been received in full.
- R2: A frame begins only on a rising edge of `fsync_i`. Bit clock edges seen after reset and before the first sync edge produce no word.
- R3: In sample mode (`code_mode_i`=0 at frame start), 8 bits are taken on 8 rising edges of `bclk_i`. The first bit lands in `word_o[7]` and the last in `word_o[0]`.
- R4: In code mode (`code_mode_i`=1 at frame start), 4 bits are taken. The first bit lands in `word_o[3]`, and `word_o[7:4]` reads 0.
- R5: When `three_bit_i`=1 in code mode, the fourth received bit is stored as 0 in `word_o[0]`. In sample mode, `three_bit_i` has no effect.
- R6: Once a word is complete, further `bclk_i` rising edges change neither `word_o` nor `word_valid_o` until the next sync edge.
- R7: `word_valid_o` is high for exactly one system clock cycle per completed word. `word_o` takes its new value in that same cycle and is otherwise held.
- R8: A sync rising edge before the word is complete restarts bit counting. Only bits after that edge make up the word.
- R9: `code_mode_i` and `three_bit_i` are sampled on the clock edge that detects the frame start. Changes to them during the frame do not affect that frame.
- R10: With two synchroniser stages, an input change first sampled on clock edge n acts on edge n+2. The output register then updates on that edge, so the strobe is high in the cycle after edge n+2. A bit clock edge detected in the same cycle as a sync edge is not counted.
- R11: Words are captured correctly whenever each high phase and each low phase of `bclk_i` lasts at least two system clock periods, which is the 4x clock-ratio limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_i | input | 1 | Asynchronous serial bit clock |
| fsync_i | input | 1 | Frame sync; the rising edge opens a frame |
| sdata_i | input | 1 | Serial data, taken on rising edges of `bclk_i` |
| code_mode_i | input | 1 | 1 selects the 4-bit code word, 0 selects the 8-bit sample word |
| three_bit_i | input | 1 | 1 forces the last code bit to zero (code mode only) |
| word_o | output | 8 | Last completed word, right-aligned |
| word_valid_o | output | 1 | Single-cycle strobe marking a new word |

## Verification
The bench drives frames that carry surplus bit clocks with toggling data. A receiver that failed to stop counting would shift that data into the word or strobe a second time. It sends a sync in the middle of a word and changes the mode pins in the middle of a frame. A receiver that kept partial bits or re-read the mode would then return a mixed word. It also clocks bits with no sync after reset and after a reset in the middle of a frame, which catches a counter that comes out of reset already armed. Fast (two-cycle phase) and slow bit clocks expose a rise detector or data synchroniser that is misaligned by one stage. A cycle-exact model catches any change in latency.

// File: rtl/frx_pkg.sv
package frx_pkg;
  // channel indices inside the synchroniser bank
  localparam int CH_BCLK = 0;
  localparam int CH_SYNC = 1;
  localparam int CH_DATA = 2;
  localparam int NUM_CH  = 3;

  // per-frame configuration captured at frame start
  typedef struct packed {
    logic code;   // 1: short code word, 0: full sample word
    logic trim;   // 1: last code bit forced to zero
  } frame_cfg_t;
endpackage

// File: rtl/frx_edge_sync.sv
module frx_edge_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_ch
    logic [CHAIN-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[CHAIN-2:0], din[g]};
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/frx_bit_core.sv
module frx_bit_core
  import frx_pkg::*;
#(
  parameter int SAMPLE_BITS = 8,
  parameter int CODE_BITS   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_rise,
  input  logic                   sync_rise,
  input  logic                   data_lvl,
  input  logic                   code_sel,
  input  logic                   trim_sel,
  output logic                   fire,
  output logic [SAMPLE_BITS-1:0] next_word,
  output logic                   armed,
  output frame_cfg_t             cfg_q
);
  localparam int CNT_W = $clog2(SAMPLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(SAMPLE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_CODE   = CNT_W'(CODE_BITS - 1);

  logic [CNT_W-1:0]       cnt;
  logic [SAMPLE_BITS-1:0] shreg;
  logic                   last_bit;
  logic                   bit_val;
  logic                   take;

  assign last_bit  = cfg_q.code ? (cnt == LAST_CODE) : (cnt == LAST_SAMPLE);
  assign bit_val   = (cfg_q.code && cfg_q.trim && (cnt == LAST_CODE)) ? 1'b0 : data_lvl;
  assign take      = armed && bit_rise && !sync_rise;
  assign fire      = take && last_bit;
  assign next_word = {shreg[SAMPLE_BITS-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      cfg_q <= '0;
    end else if (sync_rise) begin
      armed      <= 1'b1;
      cnt        <= '0;
      shreg      <= '0;
      cfg_q.code <= code_sel;
      cfg_q.trim <= trim_sel;
    end else if (take) begin
      shreg <= next_word;
      cnt   <= cnt + 1'b1;
      if (last_bit) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/frx_word_out.sv
module frx_word_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [WIDTH-1:0] next_word,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) word_o <= next_word;
    end
  end
endmodule

// File: rtl/frame_serial_rx.sv
module frame_serial_rx
  import frx_pkg::*;
#(
  parameter int SAMPLE_BITS = 8,
  parameter int CODE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bclk_i,
  input  logic                   fsync_i,
  input  logic                   sdata_i,
  input  logic                   code_mode_i,
  input  logic                   three_bit_i,
  output logic [SAMPLE_BITS-1:0] word_o,
  output logic                   word_valid_o
);
  logic [NUM_CH-1:0]      raw_in;
  logic [NUM_CH-1:0]      s_lvl;
  logic [NUM_CH-1:0]      s_rise;
  logic                   core_fire;
  logic [SAMPLE_BITS-1:0] core_word;
  logic                   frame_armed;
  frame_cfg_t             frame_cfg;
  logic                   lat_code;
  logic                   lat_trim;

  assign raw_in[CH_BCLK] = bclk_i;
  assign raw_in[CH_SYNC] = fsync_i;
  assign raw_in[CH_DATA] = sdata_i;
  assign lat_code = frame_cfg.code;
  assign lat_trim = frame_cfg.trim;

  frx_edge_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_CH)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_in),
    .lvl (s_lvl),
    .rise(s_rise)
  );

  frx_bit_core #(.SAMPLE_BITS(SAMPLE_BITS), .CODE_BITS(CODE_BITS)) u_core (
    .clk      (clk),
    .rst      (rst),
    .bit_rise (s_rise[CH_BCLK]),
    .sync_rise(s_rise[CH_SYNC]),
    .data_lvl (s_lvl[CH_DATA]),
    .code_sel (code_mode_i),
    .trim_sel (three_bit_i),
    .fire     (core_fire),
    .next_word(core_word),
    .armed    (frame_armed),
    .cfg_q    (frame_cfg)
  );

  frx_word_out #(.WIDTH(SAMPLE_BITS)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (core_fire),
    .next_word(core_word),
    .word_o   (word_o),
    .valid_o  (word_valid_o)
  );
endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
  parameter int W  = 8,
  parameter int CB = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_o,
  input logic [W-1:0] word_o,
  input logic         code_q,
  input logic         trim_q,
  input logic         armed
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !valid_o); // R1
  AST_CODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_o && code_q) |-> ((word_o >> CB) == '0)); // R4
  AST_TRIM_LAST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_o && code_q && trim_q) |-> (word_o[0] == 1'b0)); // R5
  AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !valid_o); // R6
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(word_o)); // R7
endmodule

bind frame_serial_rx frx_checker #(.W(SAMPLE_BITS), .CB(CODE_BITS)) u_frx_chk (
  .clk    (clk),
  .rst    (rst),
  .valid_o(word_valid_o),
  .word_o (word_o),
  .code_q (lat_code),
  .trim_q (lat_trim),
  .armed  (frame_armed)
);

// File: tb/frame_serial_rx_bench.sv
module frame_serial_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic       code_sel = 1'b0, trim_sel = 1'b0;
  logic [7:0] word_o;
  logic       valid_o;

  int compared = 0, mismatched = 0, cycles = 0;
  int strobes = 0;
  logic [7:0] last_word = 8'h00;

  always #2.5 clk = ~clk;

  frame_serial_rx u_frame_serial_rx (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
    .code_mode_i(code_sel), .three_bit_i(trim_sel),
    .word_o(word_o), .word_valid_o(valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model, cycle by cycle
  typedef struct packed {logic bc; logic sy; logic d;} smp_t;
  smp_t hq[$];
  int   m_armed = 0, m_cnt = 0, m_code = 0, m_trim = 0, m_acc = 0;
  int   exp_word = 0, exp_valid = 0;

  always @(posedge clk) begin
    smp_t cur;
    cur = '{bc: bclk, sy: fsync, d: sdata};
    if (rst) begin
      hq = '{3'b000, 3'b000, 3'b000};
      m_armed = 0; m_cnt = 0; m_acc = 0; m_code = 0; m_trim = 0;
      exp_word = 0; exp_valid = 0;
    end else begin
      bit br, sr, b;
      int len;
      br = hq[1].bc && !hq[2].bc;
      sr = hq[1].sy && !hq[2].sy;
      exp_valid = 0;
      if (sr) begin
        m_armed = 1; m_cnt = 0; m_acc = 0; m_code = code_sel; m_trim = trim_sel;
      end else if (m_armed != 0 && br) begin
        len = (m_code != 0) ? 4 : 8;
        b = (m_code != 0 && m_trim != 0 && m_cnt == 3) ? 1'b0 : hq[1].d;
        m_acc = ((m_acc << 1) | int'(b)) & 8'hFF;
        m_cnt++;
        if (m_cnt == len) begin
          m_armed = 0; exp_valid = 1; exp_word = m_acc;
        end
      end
      hq.push_front(cur);
      void'(hq.pop_back());
    end
  end

  // per-clock comparison, away from the active edge (R10 latency, R7 hold)
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R10/R7 model word", int'(word_o), exp_word);
      chk("R10/R7 model valid", int'(valid_o), exp_valid);
      if (valid_o) begin
        strobes++;
        last_word = word_o;
      end
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame(input bit code, input bit trim);
    code_sel = code; trim_sel = trim;
    fsync = 1'b1; wait_cyc(3);
    fsync = 1'b0; wait_cyc(3);
  endtask

  task automatic clock_bit(input bit b, input int half);
    sdata = b; wait_cyc(half);
    bclk = 1'b1; wait_cyc(half);
    bclk = 1'b0;
  endtask

  // sends 'total' bits; the first 'w' carry val MSB first, the rest alternate
  task automatic send_bits(input int val, input int w, input int total, input int half);
    for (int i = 0; i < total; i++) begin
      if (i < w) clock_bit(val[w-1-i], half);
      else       clock_bit(i[0], half);
    end
    wait_cyc(8);
  endtask

  initial begin
    wait_cyc(4);
    chk("R1 reset word", int'(word_o), 0);
    chk("R1 reset valid", int'(valid_o), 0);
    rst = 1'b0;
    wait_cyc(4);

    // R2: bit clocks before any sync
    strobes = 0;
    send_bits(8'hFF, 8, 10, 3);
    chk("R2 no word without sync", strobes, 0);
    chk("R2 word unchanged", int'(word_o), 0);

    // R3: sample word MSB first
    strobes = 0;
    start_frame(1'b0, 1'b0);
    send_bits(8'hA5, 8, 8, 3);
    chk("R3 sample word", int'(last_word), 8'hA5);
    chk("R7 one strobe", strobes, 1);

    // R4: code word
    strobes = 0;
    start_frame(1'b1, 1'b0);
    send_bits(4'h9, 4, 4, 3);
    chk("R4 code word", int'(word_o), 8'h09);
    chk("R4 one strobe", strobes, 1);

    // R5: three-bit setting in code mode and in sample mode
    start_frame(1'b1, 1'b1);
    send_bits(4'hF, 4, 4, 3);
    chk("R5 trimmed code", int'(word_o), 8'h0E);
    start_frame(1'b0, 1'b1);
    send_bits(8'hFF, 8, 8, 3);
    chk("R5 no trim in sample mode", int'(word_o), 8'hFF);

    // R6: surplus clocks after completion
    strobes = 0;
    start_frame(1'b0, 1'b0);
    send_bits(8'h3C, 8, 14, 3);
    chk("R6 surplus ignored", int'(word_o), 8'h3C);
    chk("R6 single strobe", strobes, 1);
    strobes = 0;
    start_frame(1'b1, 1'b0);
    send_bits(4'h6, 4, 9, 3);
    chk("R6 code surplus ignored", int'(word_o), 8'h06);
    chk("R6 code single strobe", strobes, 1);

    // R8: resync mid-word
    strobes = 0;
    start_frame(1'b0, 1'b0);
    send_bits(3'b111, 3, 3, 3);
    start_frame(1'b0, 1'b0);
    send_bits(8'h12, 8, 8, 3);
    chk("R8 restarted word", int'(word_o), 8'h12);
    chk("R8 one strobe", strobes, 1);

    // R9: mode pins changed mid-frame
    strobes = 0;
    start_frame(1'b0, 1'b0);
    clock_bit(1'b1, 3); clock_bit(1'b1, 3);
    code_sel = 1'b1; trim_sel = 1'b1;
    send_bits(6'b000111, 6, 6, 3);
    chk("R9 latched mode", int'(word_o), 8'hC7);
    code_sel = 1'b0; trim_sel = 1'b0;

    // R11: fastest and slow bit clocks
    start_frame(1'b0, 1'b0);
    send_bits(8'h5A, 8, 8, 2);
    chk("R11 fast clock", int'(word_o), 8'h5A);
    start_frame(1'b1, 1'b0);
    send_bits(4'hB, 4, 4, 40);
    chk("R11 slow clock", int'(word_o), 8'h0B);

    // R1: reset mid-frame, then bits without sync
    strobes = 0;
    start_frame(1'b0, 1'b0);
    send_bits(3'b101, 3, 3, 3);
    rst = 1'b1; wait_cyc(2);
    chk("R1 reset clears word", int'(word_o), 0);
    rst = 1'b0; wait_cyc(2);
    send_bits(5'b11111, 5, 5, 3);
    chk("R1 no strobe after reset", strobes, 0);
    start_frame(1'b0, 1'b0);
    send_bits(8'h81, 8, 8, 3);
    chk("R1 recovers", int'(word_o), 8'h81);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule